// File: doc/BRIEF.md
# Ordered Operand Read and Writeback Gate

This block sits between an in-order pipeline, its register file and its result-forwarding paths. Each accepted request is either a source-operand read or a destination writeback. It carries a thread number and an instruction sequence number. One cycle later the gate answers with grant or stall. For a granted read it also says whether the value comes from the register file or from forwarding. It also reports which register class the index falls in (integer, float or miscellaneous) and the index offset within that class.

Each thread keeps three pieces of state: a small list of pending writers for every register, an "oldest blocked read" sequence register and a "blocked write" sequence register. Both sequence registers hold all-ones when nothing is pending. A reader that cannot be supplied leaves its sequence number behind. From then on nothing younger is served until that reader is served. An instruction flagged non-speculative also holds back every younger request of its thread until its own writeback. A squash trims all of this state for one thread.

Top module: `operand_order_gate`

## Requirements
- R1: After reset `resp_valid` is 0, `req_ready` is 1, every writer list is empty and both sequence registers and the non-speculative flag of every thread are cleared, including when reset is applied in the middle of activity.
- R2: A read with no older pending writer of its register, and a sequence number not above the thread's oldest-blocked-read value, is granted with `resp_fwd` = 0. The oldest-blocked-read value then returns to all-ones.
- R3: A read whose only older pending writer is the list head, with that head's result marked ready by the result port, is granted with `resp_fwd` = 1 under the same ordering check. The oldest-blocked-read value is then cleared.
- R4: A read that neither source can supply stalls and records its sequence number as the oldest blocked read. After that, any request of the thread with a larger sequence number stalls (a write included) until the recorded reader is granted.
- R5: A write is granted only when its sequence number equals the head of its register's writer list and is not above the oldest blocked read. The grant removes the head. A write that is not the head stalls and is recorded as the blocked write. A granted write clears that record.
- R6: A request with `req_nonspec` = 1 that is not itself held back marks its thread as having a non-speculative instruction in flight at that sequence number. Until that instruction's write is granted, every request of the thread with a larger sequence number stalls and changes no state.
- R7: A squash of thread T at sequence S resets to all-ones any sequence register of T holding a value of S or more. It drops T's pending writers above S and clears T's non-speculative flag if the flagged instruction is above S. `req_ready` is 0 during the squash cycle, and no request is accepted then.
- R8: `resp_class` is 0 (integer, `resp_idx` = index) for an index below 32. It is 1 (float, `resp_idx` = index − 32) for 32 to 47. It is 2 (miscellaneous, `resp_idx` = index − 48) for 48 and above.
- R9: `resp_valid` is 1 in exactly the cycle after a request is accepted and 0 otherwise.
- R10: The state of each thread is private: a blocked reader or non-speculative instruction in one thread does not stall another thread.
- R11: Each register list holds up to 4 writers per thread, and an allocation to a full list is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_tid | input | 1 | Request thread |
| req_seq | input | 8 | Request sequence number |
| req_reg | input | 6 | Register index |
| req_is_write | input | 1 | 1 = writeback, 0 = operand read |
| req_nonspec | input | 1 | Instruction is non-speculative |
| alloc_valid | input | 1 | Append a pending writer |
| alloc_tid | input | 1 | Writer thread |
| alloc_reg | input | 6 | Register the writer will produce |
| alloc_seq | input | 8 | Writer sequence number |
| res_valid | input | 1 | Mark a writer's result as available |
| res_tid | input | 1 | Thread of that writer |
| res_reg | input | 6 | Register of that writer |
| res_seq | input | 8 | Sequence number of that writer |
| sq_valid | input | 1 | Squash strobe |
| sq_tid | input | 1 | Thread being squashed |
| sq_seq | input | 8 | Squash boundary sequence number |
| resp_valid | output | 1 | Response present |
| resp_grant | output | 1 | 1 = granted, 0 = stalled |
| resp_fwd | output | 1 | Granted read is served by forwarding |
| resp_class | output | 2 | Register class of the index |
| resp_idx | output | 6 | Index within its class |

## Verification
Reads are tried against a free register, a register whose older writer has no result yet, and the same register once its result is marked. This separates register-file grants, forwarding grants and true stalls. Pairs of requests in which a younger read or write follows a blocked read show whether the ordering gate holds independently of register availability. Writes issued out of list order show the head-only rule. Non-speculative sequences, squashes at and below the recorded values, cross-thread traffic and a list filled beyond capacity each exercise one kind of state clearing or isolation.

// File: rtl/operand_order_gate.sv
module operand_order_gate #(
  parameter int THREADS  = 2,
  parameter int SEQ_W    = 8,
  parameter int REG_W    = 6,
  parameter int DEPTH    = 4,
  parameter int FLT_BASE = 32,
  parameter int CTL_BASE = 48
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [((THREADS>1)?$clog2(THREADS):1)-1:0] req_tid,
  input  logic [SEQ_W-1:0]                     req_seq,
  input  logic [REG_W-1:0]                     req_reg,
  input  logic                                 req_is_write,
  input  logic                                 req_nonspec,
  input  logic                                 alloc_valid,
  input  logic [((THREADS>1)?$clog2(THREADS):1)-1:0] alloc_tid,
  input  logic [REG_W-1:0]                     alloc_reg,
  input  logic [SEQ_W-1:0]                     alloc_seq,
  input  logic                                 res_valid,
  input  logic [((THREADS>1)?$clog2(THREADS):1)-1:0] res_tid,
  input  logic [REG_W-1:0]                     res_reg,
  input  logic [SEQ_W-1:0]                     res_seq,
  input  logic                                 sq_valid,
  input  logic [((THREADS>1)?$clog2(THREADS):1)-1:0] sq_tid,
  input  logic [SEQ_W-1:0]                     sq_seq,
  output logic                                 resp_valid,
  output logic                                 resp_grant,
  output logic                                 resp_fwd,
  output logic [1:0]                           resp_class,
  output logic [REG_W-1:0]                     resp_idx
);
  localparam int NREG  = 1 << REG_W;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SEQ_W-1:0] NONE  = '1;
  localparam logic [REG_W-1:0] FLT_L = REG_W'(FLT_BASE);
  localparam logic [REG_W-1:0] CTL_L = REG_W'(CTL_BASE);

  logic [SEQ_W-1:0] wseq [THREADS][NREG][DEPTH];
  logic             wrdy [THREADS][NREG][DEPTH];
  logic [CNT_W-1:0] wcnt [THREADS][NREG];

  logic [THREADS-1:0][SEQ_W-1:0] out_rd, out_wr, ns_seq;
  logic [THREADS-1:0]            ns_act;

  assign req_ready = !sq_valid;
  wire acc = req_valid && req_ready;

  wire [CNT_W-1:0] cnt_q   = wcnt[req_tid][req_reg];
  wire [SEQ_W-1:0] head_sq = wseq[req_tid][req_reg][0];
  wire             head_rd = wrdy[req_tid][req_reg][0];
  wire [SEQ_W-1:0] next_sq = wseq[req_tid][req_reg][PTR_W'(1)];

  wire older    = (cnt_q != '0) && (head_sq < req_seq);
  wire can_rf   = !older;
  wire can_fwd  = older && head_rd && ((cnt_q == CNT_W'(1)) || (next_sq > req_seq));
  wire can_wr   = (cnt_q != '0) && (head_sq == req_seq);
  wire order_ok = req_seq <= out_rd[req_tid];
  wire ns_block = ns_act[req_tid] && (req_seq > ns_seq[req_tid]);

  wire grant = !ns_block && order_ok &&
               (req_is_write ? can_wr : (can_rf || can_fwd));
  wire pop   = acc && grant && req_is_write;

  wire             a_same = pop && (alloc_tid == req_tid) && (alloc_reg == req_reg);
  wire [CNT_W-1:0] a_pos  = wcnt[alloc_tid][alloc_reg] - CNT_W'(a_same);
  wire             push   = alloc_valid && !sq_valid && (a_pos < CNT_W'(DEPTH));

  wire m_same = pop && (res_tid == req_tid) && (res_reg == req_reg);
  logic             mark_hit;
  logic [PTR_W-1:0] mark_pos;
  always_comb begin
    mark_hit = 1'b0;
    mark_pos = '0;
    for (int d = 0; d < DEPTH; d++)
      if (res_valid && (CNT_W'(d) < wcnt[res_tid][res_reg]) &&
          (wseq[res_tid][res_reg][d] == res_seq)) begin
        mark_hit = 1'b1;
        mark_pos = PTR_W'(d);
      end
  end

  logic [CNT_W-1:0] sq_keep [NREG];
  always_comb
    for (int r = 0; r < NREG; r++) begin
      sq_keep[r] = '0;
      for (int d = 0; d < DEPTH; d++)
        if ((CNT_W'(d) < wcnt[sq_tid][r]) && (wseq[sq_tid][r][d] <= sq_seq))
          sq_keep[r] = sq_keep[r] + 1'b1;
    end

  logic [1:0]       cls;
  logic [REG_W-1:0] idx;
  always_comb
    if (req_reg < FLT_L)      begin cls = 2'd0; idx = req_reg;         end
    else if (req_reg < CTL_L) begin cls = 2'd1; idx = req_reg - FLT_L; end
    else                      begin cls = 2'd2; idx = req_reg - CTL_L; end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++)
        for (int r = 0; r < NREG; r++)
          wcnt[t][r] <= '0;
      out_rd     <= {THREADS{NONE}};
      out_wr     <= {THREADS{NONE}};
      ns_seq     <= '0;
      ns_act     <= '0;
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_fwd   <= 1'b0;
      resp_class <= 2'd0;
      resp_idx   <= '0;
    end else if (sq_valid) begin
      resp_valid <= 1'b0;
      for (int r = 0; r < NREG; r++)
        wcnt[sq_tid][r] <= sq_keep[r];
      if (out_rd[sq_tid] >= sq_seq) out_rd[sq_tid] <= NONE;
      if (out_wr[sq_tid] >= sq_seq) out_wr[sq_tid] <= NONE;
      if (ns_act[sq_tid] && (ns_seq[sq_tid] > sq_seq)) ns_act[sq_tid] <= 1'b0;
    end else begin
      resp_valid <= acc;
      if (acc) begin
        resp_grant <= grant;
        resp_fwd   <= grant && !req_is_write && !can_rf;
        resp_class <= cls;
        resp_idx   <= idx;
      end
      if (acc && !ns_block) begin
        if (req_nonspec) begin
          ns_act[req_tid] <= 1'b1;
          ns_seq[req_tid] <= req_seq;
        end
        if (!req_is_write) begin
          if (can_rf || can_fwd) begin
            if (order_ok) out_rd[req_tid] <= NONE;
          end else
            out_rd[req_tid] <= req_seq;
        end else if (can_wr) begin
          if (order_ok) begin
            out_wr[req_tid] <= NONE;
            if (req_nonspec || (ns_act[req_tid] && ns_seq[req_tid] == req_seq))
              ns_act[req_tid] <= 1'b0;
          end
        end else
          out_wr[req_tid] <= req_seq;
      end
      if (pop) begin
        for (int d = 0; d < DEPTH - 1; d++) begin
          wseq[req_tid][req_reg][d] <= wseq[req_tid][req_reg][d+1];
          wrdy[req_tid][req_reg][d] <= wrdy[req_tid][req_reg][d+1];
        end
        wrdy[req_tid][req_reg][DEPTH-1] <= 1'b0;
        wcnt[req_tid][req_reg] <= cnt_q - 1'b1;
      end
      if (push) begin
        wseq[alloc_tid][alloc_reg][a_pos[PTR_W-1:0]] <= alloc_seq;
        wrdy[alloc_tid][alloc_reg][a_pos[PTR_W-1:0]] <= 1'b0;
        wcnt[alloc_tid][alloc_reg] <= a_pos + 1'b1;
      end
      if (mark_hit && !(m_same && mark_pos == '0))
        wrdy[res_tid][res_reg][mark_pos - PTR_W'(m_same)] <= 1'b1;
    end
  end
endmodule

// File: rtl/operand_order_gate_chk.sv
module operand_order_gate_chk #(
  parameter int THREADS = 2,
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [TID_W-1:0]              req_tid,
  input logic [SEQ_W-1:0]              req_seq,
  input logic                          req_is_write,
  input logic                          sq_valid,
  input logic                          resp_valid,
  input logic                          resp_grant,
  input logic                          resp_fwd,
  input logic [1:0]                    resp_class,
  input logic [THREADS-1:0]            ns_act,
  input logic [THREADS-1:0][SEQ_W-1:0] ns_seq,
  input logic [THREADS-1:0][SEQ_W-1:0] out_wr
);
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid); // R9
  AST_SQUASH_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !resp_valid); // R7
  AST_NS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ns_act[req_tid] && (req_seq > ns_seq[req_tid])
    |=> resp_valid && !resp_grant); // R6
  AST_WRITE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(req_is_write) |-> !resp_fwd); // R5
  AST_WRSEQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_grant && $past(req_is_write)
    |-> out_wr[$past(req_tid)] == '1); // R5
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_class != 2'd3); // R8
endmodule

bind operand_order_gate operand_order_gate_chk #(
  .THREADS(THREADS), .SEQ_W(SEQ_W), .TID_W((THREADS>1)?$clog2(THREADS):1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_tid(req_tid), .req_seq(req_seq), .req_is_write(req_is_write),
  .sq_valid(sq_valid), .resp_valid(resp_valid), .resp_grant(resp_grant),
  .resp_fwd(resp_fwd), .resp_class(resp_class), .ns_act(ns_act),
  .ns_seq(ns_seq), .out_wr(out_wr)
);

// File: tb/operand_order_gate_test.sv
module operand_order_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_is_write = 0, req_nonspec = 0;
  logic req_tid = 0, alloc_tid = 0, res_tid = 0, sq_tid = 0;
  logic [7:0] req_seq = 0, alloc_seq = 0, res_seq = 0, sq_seq = 0;
  logic [5:0] req_reg = 0, alloc_reg = 0, res_reg = 0;
  logic alloc_valid = 0, res_valid = 0, sq_valid = 0;
  logic req_ready, resp_valid, resp_grant, resp_fwd;
  logic [1:0] resp_class;
  logic [5:0] resp_idx;

  operand_order_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tid(req_tid), .req_seq(req_seq), .req_reg(req_reg),
    .req_is_write(req_is_write), .req_nonspec(req_nonspec),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_reg(alloc_reg),
    .alloc_seq(alloc_seq), .res_valid(res_valid), .res_tid(res_tid),
    .res_reg(res_reg), .res_seq(res_seq), .sq_valid(sq_valid),
    .sq_tid(sq_tid), .sq_seq(sq_seq), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_fwd(resp_fwd), .resp_class(resp_class),
    .resp_idx(resp_idx)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [1:0] REQ = 2'd0, ALC = 2'd1, RES = 2'd2, SQ = 2'd3;
  // {op, tid, seq, reg, write, nonspec, exp_grant, exp_fwd, exp_class, tag}
  localparam int NV = 54;
  localparam logic [26:0] VEC [NV] = '{
    {REQ,1'b0,8'd10,6'd5, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd2},  // R2
    {ALC,1'b0,8'd11,6'd5, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd12,6'd5, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {REQ,1'b0,8'd13,6'd7, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {RES,1'b0,8'd11,6'd5, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd12,6'd5, 1'b0,1'b0,1'b1,1'b1,2'd0,4'd3},  // R3
    {REQ,1'b0,8'd13,6'd7, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd2},  // R2
    {REQ,1'b0,8'd11,6'd5, 1'b1,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {REQ,1'b0,8'd14,6'd5, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {ALC,1'b0,8'd20,6'd9, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd21,6'd9, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd21,6'd9, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd5},  // R5
    {REQ,1'b0,8'd20,6'd9, 1'b1,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {REQ,1'b0,8'd21,6'd9, 1'b1,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {ALC,1'b0,8'd30,6'd3, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd33,6'd4, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd31,6'd3, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {REQ,1'b0,8'd33,6'd4, 1'b1,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {REQ,1'b0,8'd30,6'd3, 1'b1,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {REQ,1'b0,8'd31,6'd3, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd2},  // R2
    {REQ,1'b0,8'd33,6'd4, 1'b1,1'b0,1'b1,1'b0,2'd0,4'd5},  // R5
    {ALC,1'b0,8'd40,6'd40,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd40,6'd1, 1'b0,1'b1,1'b1,1'b0,2'd0,4'd6},  // R6
    {REQ,1'b0,8'd41,6'd2, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd6},  // R6
    {REQ,1'b1,8'd60,6'd2, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd10}, // R10
    {REQ,1'b0,8'd40,6'd40,1'b1,1'b0,1'b1,1'b0,2'd1,4'd6},  // R6
    {REQ,1'b0,8'd41,6'd2, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd6},  // R6
    {REQ,1'b0,8'd42,6'd50,1'b0,1'b0,1'b1,1'b0,2'd2,4'd8},  // R8
    {REQ,1'b0,8'd43,6'd47,1'b0,1'b0,1'b1,1'b0,2'd1,4'd8},  // R8
    {ALC,1'b0,8'd70,6'd10,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd71,6'd10,1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {REQ,1'b0,8'd72,6'd11,1'b0,1'b0,1'b0,1'b0,2'd0,4'd4},  // R4
    {SQ, 1'b0,8'd71,6'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd72,6'd11,1'b0,1'b0,1'b1,1'b0,2'd0,4'd7},  // R7
    {ALC,1'b0,8'd80,6'd12,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {SQ, 1'b0,8'd75,6'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd76,6'd12,1'b0,1'b0,1'b1,1'b0,2'd0,4'd7},  // R7
    {REQ,1'b0,8'd90,6'd1, 1'b0,1'b1,1'b1,1'b0,2'd0,4'd6},  // R6
    {REQ,1'b0,8'd91,6'd1, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd6},  // R6
    {SQ, 1'b0,8'd89,6'd0, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd91,6'd1, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd7},  // R7
    {ALC,1'b1,8'd61,6'd2, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b1,8'd62,6'd2, 1'b0,1'b0,1'b0,1'b0,2'd0,4'd10}, // R10
    {REQ,1'b0,8'd92,6'd2, 1'b0,1'b0,1'b1,1'b0,2'd0,4'd10}, // R10
    {ALC,1'b0,8'd100,6'd20,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd101,6'd20,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd102,6'd20,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd103,6'd20,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {ALC,1'b0,8'd104,6'd20,1'b0,1'b0,1'b0,1'b0,2'd0,4'd0},
    {REQ,1'b0,8'd100,6'd20,1'b1,1'b0,1'b1,1'b0,2'd0,4'd11}, // R11
    {REQ,1'b0,8'd101,6'd20,1'b1,1'b0,1'b1,1'b0,2'd0,4'd11}, // R11
    {REQ,1'b0,8'd102,6'd20,1'b1,1'b0,1'b1,1'b0,2'd0,4'd11}, // R11
    {REQ,1'b0,8'd103,6'd20,1'b1,1'b0,1'b1,1'b0,2'd0,4'd11}, // R11
    {REQ,1'b0,8'd104,6'd20,1'b1,1'b0,1'b0,1'b0,2'd0,4'd11}  // R11
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic t, input logic [7:0] s, input logic [5:0] r,
                        input logic w, input logic ns);
    req_valid = 1; req_tid = t; req_seq = s; req_reg = r;
    req_is_write = w; req_nonspec = ns;
    @(negedge clk);
    req_valid = 0; req_nonspec = 0;
  endtask

  task automatic do_alloc(input logic t, input logic [7:0] s, input logic [5:0] r);
    alloc_valid = 1; alloc_tid = t; alloc_seq = s; alloc_reg = r;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", {14'd0, resp_valid, req_ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      logic [5:0]  ei;
      v = VEC[i];
      case (v[26:25])
        REQ: begin
          do_req(v[24], v[23:16], v[15:10], v[9], v[8]);
          ei = (v[5:4] == 2'd0) ? v[15:10] :
               (v[5:4] == 2'd1) ? v[15:10] - 6'd32 : v[15:10] - 6'd48;
          tests++;
          if ({resp_valid, resp_grant, resp_fwd, resp_class, resp_idx} !==
              {1'b1, v[7], v[6], v[5:4], ei}) begin
            fails++;
            $display("FAIL R%0d vector %0d: actual v%b g%b f%b c%0d i%0d expected v1 g%b f%b c%0d i%0d",
                     v[3:0], i, resp_valid, resp_grant, resp_fwd, resp_class, resp_idx,
                     v[7], v[6], v[5:4], ei);
          end
        end
        ALC: do_alloc(v[24], v[23:16], v[15:10]);
        RES: begin
          res_valid = 1; res_tid = v[24]; res_seq = v[23:16]; res_reg = v[15:10];
          @(negedge clk);
          res_valid = 0;
        end
        default: begin
          sq_valid = 1; sq_tid = v[24]; sq_seq = v[23:16];
          @(negedge clk);
          sq_valid = 0;
        end
      endcase
    end

    // R9: response lasts one cycle only
    do_req(1'b0, 8'd110, 6'd30, 1'b0, 1'b0);
    check("R9 response present", {15'd0, resp_valid}, 16'd1);
    @(negedge clk);
    check("R9 response drops", {15'd0, resp_valid}, 16'd0);

    // R7: request during a squash is refused
    sq_valid = 1; sq_tid = 1'b1; sq_seq = 8'd200;
    req_valid = 1; req_tid = 1'b0; req_seq = 8'd111; req_reg = 6'd31; req_is_write = 0;
    #1 check("R7 ready low in squash", {15'd0, req_ready}, 16'd0);
    @(negedge clk);
    sq_valid = 0; req_valid = 0;
    check("R7 no response in squash", {15'd0, resp_valid}, 16'd0);

    // R8: integer class with a large index
    do_req(1'b0, 8'd112, 6'd31, 1'b0, 1'b0);
    check("R8 int class", {8'd0, resp_class, resp_idx}, {8'd0, 2'd0, 6'd31});
    do_req(1'b0, 8'd113, 6'd32, 1'b0, 1'b0);
    check("R8 float base", {8'd0, resp_class, resp_idx}, {8'd0, 2'd1, 6'd0});

    // R1: reset in the middle clears a blocked reader and writer lists
    do_alloc(1'b0, 8'd120, 6'd13);
    do_req(1'b0, 8'd121, 6'd13, 1'b0, 1'b0);
    check("R1 setup stall", {14'd0, resp_valid, resp_grant}, 16'h0002);
    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears response", {15'd0, resp_valid}, 16'd0);
    rst_n = 1;
    do_req(1'b0, 8'd122, 6'd14, 1'b0, 1'b0);
    check("R1 ordering cleared", {14'd0, resp_valid, resp_grant}, 16'h0003);
    do_req(1'b0, 8'd123, 6'd13, 1'b0, 1'b0);
    check("R1 writer list cleared", {13'd0, resp_valid, resp_grant, resp_fwd}, 16'h0006);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule